// File: doc/BRIEF.md
# Encoded Post Divider with Selectable Source

This block is one output-clock stage. It picks one of four source strobes and divides it by a modulus chosen from a fixed, irregular set. All sources are single-cycle enable strobes on the system clock `clk`, so the stage is fully synchronous. The source strobes are the reference and PLL A, B and C.

Two banks each hold a source select and a divide code, and the `bank_sel` input chooses which bank applies. A new source or modulus is adopted only when the running period ends, so a switch never produces a runt pulse. Power-down, when enabled for this stage, drives the output low. A separate active-low enable releases the output driver to high impedance.

Top module: `outclk_divstage`

## Requirements
- R1: The 2-bit source select picks `src_stb[0]` (reference) for 00, `src_stb[1]` (PLL A) for 01, `src_stb[2]` (PLL B) for 10 and `src_stb[3]` (PLL C) for 11.
- R2: Divide codes 0 through 15 give moduli 1, 2, 3, 4, 5, 6, 8, 9, 10, 12, 15, 16, 18, 20, 25 and 50, in that order. One output period lasts that many strobes of the selected source.
- R3: With `bank_sel` low, the pair `sel_lo`/`code_lo` is used. With `bank_sel` high, the pair `sel_hi`/`code_hi` is used.
- R4: While `pd_in` and `pd_en` are both high, `clk_out` is low in the same cycle, and the divider restarts at a fresh period on the first strobe after release. `pd_in` has no effect while `pd_en` is low.
- R5: While `oe_n` is high, `clk_oe` is low and `clk_out` is high impedance. While `oe_n` is low, `clk_oe` is high.
- R6: After reset, the stage uses source 00 with code 0, so the reference passes undivided, and `clk_out` is low until the first reference strobe.
- R7: For an even modulus N, the output is high for N/2 strobes of each period. For an odd modulus N > 1, it is high for floor(N/2) strobes.
- R8: The bank contents are sampled only at the terminal strobe that ends a period. That strobe starts the new period high, using the new source and modulus.
- R9: With modulus 1, `clk_out` in cycle t+1 equals the selected strobe in cycle t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_stb | input | 4 | Source strobes: reference, PLL A, PLL B, PLL C |
| bank_sel | input | 1 | Bank choice (0 = low bank, 1 = high bank) |
| sel_lo | input | 2 | Source select, low bank |
| code_lo | input | 4 | Divide code, low bank |
| sel_hi | input | 2 | Source select, high bank |
| code_hi | input | 4 | Divide code, high bank |
| pd_in | input | 1 | Power-down request |
| pd_en | input | 1 | Stage power-down enable |
| oe_n | input | 1 | Active-low output enable |
| clk_out | output | 1 | Divided clock (tristated) |
| clk_oe | output | 1 | Output driver enable |

## Verification
The hardest situation to reach is a bank change that arrives in the middle of a long period while the source strobes are sparse and irregular. In that case the old modulus must run to its terminal strobe before anything changes. The stimulus gets there by rewriting codes and selects, or flipping `bank_sel`, at random cycles while the strobes fire at random. This includes a switch from modulus 50 to modulus 1. A behavioural model in the bench tracks each period position and is compared with the output on every clock.

// File: rtl/outclk_divstage.sv
module outclk_divstage #(
  parameter int SRC_N  = 4,
  parameter int CODE_W = 4,
  parameter int CNT_W  = 6,
  localparam int SEL_W = $clog2(SRC_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  src_stb,
  input  logic              bank_sel,
  input  logic [SEL_W-1:0]  sel_lo,
  input  logic [CODE_W-1:0] code_lo,
  input  logic [SEL_W-1:0]  sel_hi,
  input  logic [CODE_W-1:0] code_hi,
  input  logic              pd_in,
  input  logic              pd_en,
  input  logic              oe_n,
  output wire               clk_out,
  output logic              clk_oe
);

  function automatic logic [CNT_W-1:0] modulus(input logic [CODE_W-1:0] c);
    case (c)
      4'd0:  modulus = CNT_W'(1);
      4'd1:  modulus = CNT_W'(2);
      4'd2:  modulus = CNT_W'(3);
      4'd3:  modulus = CNT_W'(4);
      4'd4:  modulus = CNT_W'(5);
      4'd5:  modulus = CNT_W'(6);
      4'd6:  modulus = CNT_W'(8);
      4'd7:  modulus = CNT_W'(9);
      4'd8:  modulus = CNT_W'(10);
      4'd9:  modulus = CNT_W'(12);
      4'd10: modulus = CNT_W'(15);
      4'd11: modulus = CNT_W'(16);
      4'd12: modulus = CNT_W'(18);
      4'd13: modulus = CNT_W'(20);
      4'd14: modulus = CNT_W'(25);
      default: modulus = CNT_W'(50);
    endcase
  endfunction

  logic [SEL_W-1:0]  act_sel;
  logic [CODE_W-1:0] act_code;
  logic [CNT_W-1:0]  cnt;
  logic              q;

  wire [CNT_W-1:0] nmod    = modulus(act_code);
  wire [CNT_W-1:0] half    = nmod >> 1;
  wire [CNT_W-1:0] last    = nmod - CNT_W'(1);
  wire [CNT_W-1:0] cnt_inc = cnt + CNT_W'(1);
  wire             stb     = src_stb[act_sel];
  wire             pwrdn   = pd_in & pd_en;
  wire             term    = stb && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_sel  <= '0;
      act_code <= '0;
      cnt      <= '0;
      q        <= 1'b0;
    end else if (pwrdn) begin
      cnt <= last;
      q   <= 1'b0;
    end else if (term) begin
      cnt      <= '0;
      q        <= 1'b1;
      act_sel  <= bank_sel ? sel_hi  : sel_lo;
      act_code <= bank_sel ? code_hi : code_lo;
    end else if (stb) begin
      cnt <= cnt_inc;
      q   <= (cnt_inc < half);
    end else if (nmod == CNT_W'(1)) begin
      q <= 1'b0;
    end
  end

  assign clk_oe  = ~oe_n;
  assign clk_out = oe_n ? 1'bz : (q & ~pwrdn);

endmodule

module outclk_divstage_chk #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              q,
  input logic              term,
  input logic              pwrdn,
  input logic              oe_n,
  input logic              clk_oe,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  nmod,
  input logic [CODE_W-1:0] act_code
);

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < nmod);

  assert_pd_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn |=> !q);

  assert_oe_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !clk_oe);

  assert_fall_at_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(q) && !$past(pwrdn) && $past(nmod) > 1) |-> (cnt == ($past(nmod) >> 1)));

  assert_reload_at_term_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_code) |-> $past(term));

endmodule

bind outclk_divstage outclk_divstage_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .q(q), .term(term), .pwrdn(pwrdn), .oe_n(oe_n),
  .clk_oe(clk_oe), .cnt(cnt), .nmod(nmod), .act_code(act_code)
);

// File: tb/test_outclk_divstage.sv
module test_outclk_divstage;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [3:0] src_stb = '0;
  logic bank_sel = 0;
  logic [1:0] sel_lo = '0, sel_hi = '0;
  logic [3:0] code_lo = '0, code_hi = '0;
  logic pd_in = 0, pd_en = 0, oe_n = 0;
  wire  clk_out;
  logic clk_oe;

  outclk_divstage i_outclk_divstage (
    .clk(clk), .rst_n(rst_n), .src_stb(src_stb), .bank_sel(bank_sel),
    .sel_lo(sel_lo), .code_lo(code_lo), .sel_hi(sel_hi), .code_hi(code_hi),
    .pd_in(pd_in), .pd_en(pd_en), .oe_n(oe_n), .clk_out(clk_out), .clk_oe(clk_oe)
  );

  always #(PERIOD/2) clk = ~clk;

  int mods[16] = '{1, 2, 3, 4, 5, 6, 8, 9, 10, 12, 15, 16, 18, 20, 25, 50};
  int tests = 0, fails = 0;
  string cur_req = "R6";

  int m_sel, m_n, m_pos;
  bit m_q;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_n = 1; m_pos = 0; m_q = 0;
    end else if (pd_in && pd_en) begin
      m_q = 0; m_pos = m_n - 1;
    end else if (src_stb[m_sel]) begin
      m_pos = (m_pos + 1) % m_n;
      if (m_pos == 0) begin
        m_q = 1;
        m_sel = bank_sel ? int'(sel_hi) : int'(sel_lo);
        m_n = mods[bank_sel ? code_hi : code_lo];
      end else m_q = (m_pos < m_n / 2);
    end else if (m_n == 1) m_q = 0;
  end

  task automatic check(input bit cond, input string req, input string what, input int act, input int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    bit eo, ev;
    @(negedge clk);
    eo = !oe_n;
    ev = m_q && !(pd_in && pd_en);
    check(clk_oe === eo, cur_req, "clk_oe", int'(clk_oe), int'(eo));
    if (eo) check(clk_out === ev, cur_req, "clk_out", int'(clk_out), int'(ev));
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit prev;
    int highs;
    repeat (3) @(negedge clk);
    check(clk_out === 1'b0, "R6", "reset level", int'(clk_out), 0);
    rst_n = 1;
    cur_req = "R6";
    for (int i = 0; i < 20; i++) begin
      tick();
      src_stb = 4'($urandom());
    end
    cur_req = "R9";
    for (int i = 0; i < 40; i++) begin
      prev = src_stb[0];
      tick();
      check(clk_out === prev, "R9", "pass-through", int'(clk_out), int'(prev));
      src_stb = 4'($urandom());
    end
    cur_req = "R2";
    src_stb = 4'b0001;
    for (int c = 0; c < 16; c++) begin
      code_lo = 4'(c);
      repeat (110) tick();
      highs = 0;
      for (int k = 0; k < 2 * mods[c]; k++) begin
        tick();
        if (clk_out === 1'b1) highs++;
      end
      check(highs == ((mods[c] == 1) ? 2 : 2 * (mods[c] / 2)), "R7", "high strobes", highs,
            (mods[c] == 1) ? 2 : 2 * (mods[c] / 2));
    end
    cur_req = "R1";
    code_lo = 4'd2;
    for (int s = 0; s < 4; s++) begin
      sel_lo = 2'(s);
      for (int i = 0; i < 60; i++) begin
        tick();
        src_stb = 4'($urandom());
      end
    end
    cur_req = "R3";
    sel_lo = 2'd1; code_lo = 4'd3; sel_hi = 2'd3; code_hi = 4'd4;
    for (int i = 0; i < 300; i++) begin
      tick();
      src_stb = 4'($urandom());
      if (($urandom() % 17) == 0) bank_sel = ~bank_sel;
    end
    cur_req = "R8";
    bank_sel = 0; sel_lo = 2'd0; code_lo = 4'd15;
    for (int i = 0; i < 300; i++) begin
      tick();
      src_stb = 4'($urandom());
      if (i == 70) code_lo = 4'd0;
      if (i > 150 && ($urandom() % 11) == 0) begin
        code_lo = 4'($urandom()); sel_lo = 2'($urandom());
      end
    end
    cur_req = "R4";
    code_lo = 4'd5; sel_lo = 2'd0;
    for (int i = 0; i < 300; i++) begin
      tick();
      src_stb = 4'($urandom());
      pd_en = (i > 150);
      if (($urandom() % 9) == 0) pd_in = ~pd_in;
    end
    pd_in = 1; pd_en = 1;
    tick(); tick();
    check(clk_out === 1'b0, "R4", "powered down", int'(clk_out), 0);
    pd_in = 0;
    cur_req = "R5";
    oe_n = 1;
    for (int i = 0; i < 20; i++) begin
      tick();
      src_stb = 4'($urandom());
    end
    oe_n = 0;
    repeat (20) tick();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule